// File: doc/BRIEF.md
# I2C Register Port with Word-Wise Auto-Increment

This block is a bus slave that lets an I2C host read and write a small internal map of registers. Each map entry holds one to five bytes. The host never sees the byte granularity of the storage. It addresses whole entries through a 16-bit subaddress. A burst moves through consecutive entries, and the pointer steps by one entry each time a complete word has gone across the bus.

The block takes the raw SCL and SDA levels, which are oversampled by the system clock. It drives only a pull-down enable for SDA and never drives a high level. Two strap inputs fill two bits of the 7-bit bus address, so up to four instances can share one bus.

A write sends the address byte, then the subaddress high byte and low byte, then data, most significant byte of each word first. A read first writes the subaddress in the same way. The host then issues a repeated start and an address byte with the direction bit set, and clocks data out until it answers a byte with NACK.

Top module: `i2c_regport`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits, sent MSB first, equal 0,1,1,0,1,addr_strap[1],addr_strap[0]. Bit 0 of that byte selects read (1) or write (0). On a mismatch it does not acknowledge, and it ignores the bus until the next start.
- R2: A start (SDA falling while SCL is high) is recognised at any point, including in the middle of a byte, and makes the next byte an address byte. A stop (SDA rising while SCL is high) is also recognised at any point and returns the block to idle with SDA released.
- R3: After a write address byte, the next two bytes form the subaddress, high byte first. The block acknowledges the low byte only if the subaddress is below NUM_ENTRIES (8 by default). Otherwise it withholds the acknowledge and goes idle.
- R4: Entry i is ((i mod 5) + 1) bytes wide. Its bytes cross the bus most significant first, and a read of a freshly reset entry returns zeros.
- R5: Each time the last byte of an entry's word has been transferred, the subaddress advances by one. A burst therefore continues into the next entry with that entry's own width.
- R6: A written word reaches storage only at the end of the acknowledge of its final byte. A stop or start before then leaves the entry unchanged.
- R7: A data byte written while the subaddress is beyond the last entry is acknowledged by no one and stored nowhere, and the block goes idle.
- R8: In a read, the block shifts data out while the host acknowledges. Once it is past the last entry, it keeps sending the last entry's word again. A host NACK ends the read and releases SDA.
- R9: The block only ever pulls SDA low. It changes its SDA drive only after it has seen SCL fall (or on a start or stop), and it never drives SDA while the host is sending a bit.
- R10: After reset the block is idle, with SDA released and all entries cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| addr_strap | input | 2 | Strap value for address bits 2 and 1 (bit 1 of the strap is the higher) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Every bus edge passes through two synchroniser flops before the edge detector sees it, and one more register drives sda_oe. The pull-down for an acknowledge or a read bit therefore appears three system clocks after SCL falls. The bench drives each bus phase 10 clocks after the preceding SCL edge and samples SDA 10 clocks into the SCL-high time. Each result is well settled before it is read, and no sample falls near an edge. A commit to storage happens at the SCL fall that ends the final acknowledge, so the bench checks stored words only by reading them back in a later transfer. Throughout every host-driven SCL-high time, the bench compares sda_oe with zero on each clock.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKO,
    ST_TX,
    ST_ACKI
  } rp_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_SUBH,
    BK_SUBL,
    BK_DATA
  } rp_kind_t;

  localparam int WORD_BYTES_MAX = 5;
  localparam int WORD_BITS      = 8 * WORD_BYTES_MAX;

  // Byte count of one map entry: widths cycle 1..5 across the map.
  function automatic logic [2:0] entry_bytes(input int unsigned idx);
    return 3'((idx % 5) + 1);
  endfunction

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic                   scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_lvl;
      sda_q  <= sda_lvl;
    end
  end

  assign scl_lvl    = scl_sh[SYNC_STAGES-1];
  assign sda_lvl    = sda_sh[SYNC_STAGES-1];
  assign scl_rise   = scl_lvl & ~scl_q;
  assign scl_fall   = ~scl_lvl & scl_q;
  assign cond_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign cond_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_rp_regfile.sv
module i2c_rp_regfile
  import i2c_rp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [WORD_BITS-1:0] wr_word,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [WORD_BITS-1:0] rd_word,
  output logic [2:0]           rd_bytes
);

  logic [WORD_BITS-1:0] words [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    localparam logic [2:0]           NB   = entry_bytes(i);
    localparam logic [WORD_BITS-1:0] MASK = (WORD_BITS'(1) << (8 * NB)) - WORD_BITS'(1);
    logic [WORD_BITS-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))    q <= wr_word & MASK;
    end
    assign words[i] = q;
  end

  assign rd_word  = words[rd_idx];
  assign rd_bytes = entry_bytes(32'(rd_idx));

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_rp_pkg::*;
#(
  parameter int         NUM_ENTRIES = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_FIXED  = 5'b01101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_strap,
  output logic       sda_oe
);

  localparam int                IDX_W    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int                SUB_W    = 16;
  localparam logic [SUB_W-1:0]  LAST_SUB = SUB_W'(NUM_ENTRIES - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, cond_start, cond_stop;

  i2c_rp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_lvl, .sda_lvl, .scl_rise, .scl_fall, .cond_start, .cond_stop
  );

  rp_state_t            state;
  rp_kind_t             kind;
  logic [3:0]           bitc;
  logic [7:0]           sh, tx_sh, sub_hi;
  logic [SUB_W-1:0]     sub;
  logic [2:0]           bidx;
  logic [WORD_BITS-1:0] wbuf;
  logic                 rd_mode, commit_pend, got_ack;

  logic [IDX_W-1:0]     ridx;
  logic [WORD_BITS-1:0] rd_word;
  logic [2:0]           rd_bytes, boff;
  logic [7:0]           cur_byte;
  logic                 word_last, wr_en;

  assign ridx      = (sub > LAST_SUB) ? LAST_IDX : sub[IDX_W-1:0];
  assign boff      = rd_bytes - 3'd1 - bidx;
  assign cur_byte  = 8'(rd_word >> {boff, 3'b000});
  assign word_last = (bidx == rd_bytes - 3'd1);
  assign wr_en     = (state == ST_ACKO) && scl_fall && commit_pend && !cond_start && !cond_stop;

  i2c_rp_regfile #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_regs (
    .clk, .rst_n,
    .wr_en, .wr_idx(ridx), .wr_word(wbuf),
    .rd_idx(ridx), .rd_word, .rd_bytes
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  kind <= BK_ADDR;  bitc <= '0;
      sh <= '0;  tx_sh <= '0;  sub_hi <= '0;  sub <= '0;
      bidx <= '0;  wbuf <= '0;  rd_mode <= 1'b0;
      commit_pend <= 1'b0;  got_ack <= 1'b0;  sda_oe <= 1'b0;
    end else if (cond_stop) begin
      state <= ST_IDLE;  sda_oe <= 1'b0;  commit_pend <= 1'b0;
    end else if (cond_start) begin
      state <= ST_RX;  kind <= BK_ADDR;  bitc <= '0;
      sda_oe <= 1'b0;  commit_pend <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bitc < 4'd8) begin
            sh   <= {sh[6:0], sda_lvl};
            bitc <= bitc + 4'd1;
          end else if (scl_fall && bitc == 4'd8) begin
            case (kind)
              BK_ADDR: begin
                if (sh[7:1] == {ADDR_FIXED, addr_strap}) begin
                  sda_oe <= 1'b1;  state <= ST_ACKO;
                  rd_mode <= sh[0];  bidx <= '0;  wbuf <= '0;
                  kind <= sh[0] ? BK_DATA : BK_SUBH;
                end else begin
                  state <= ST_IDLE;
                end
              end
              BK_SUBH: begin
                sub_hi <= sh;  sda_oe <= 1'b1;
                state <= ST_ACKO;  kind <= BK_SUBL;
              end
              BK_SUBL: begin
                if ({sub_hi, sh} < SUB_W'(NUM_ENTRIES)) begin
                  sub <= {sub_hi, sh};  bidx <= '0;  wbuf <= '0;
                  sda_oe <= 1'b1;  state <= ST_ACKO;  kind <= BK_DATA;
                end else begin
                  state <= ST_IDLE;
                end
              end
              default: begin
                if (sub > LAST_SUB) begin
                  state <= ST_IDLE;
                end else begin
                  wbuf   <= {wbuf[WORD_BITS-9:0], sh};
                  sda_oe <= 1'b1;  state <= ST_ACKO;
                  if (word_last) commit_pend <= 1'b1;
                  else           bidx <= bidx + 3'd1;
                end
              end
            endcase
          end
        end
        ST_ACKO: begin
          if (scl_fall) begin
            bitc <= '0;
            if (rd_mode) begin
              state <= ST_TX;  tx_sh <= cur_byte;  sda_oe <= ~cur_byte[7];
            end else begin
              state <= ST_RX;  sda_oe <= 1'b0;
              if (commit_pend) begin
                commit_pend <= 1'b0;  sub <= sub + 16'd1;
                bidx <= '0;  wbuf <= '0;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitc == 4'd7) begin
              state <= ST_ACKI;  sda_oe <= 1'b0;
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              bitc <= bitc + 4'd1;
            end
          end
        end
        ST_ACKI: begin
          if (scl_rise) begin
            got_ack <= ~sda_lvl;
            if (!sda_lvl) begin
              if (word_last) begin
                bidx <= '0;
                if (sub < LAST_SUB) sub <= sub + 16'd1;
              end else begin
                bidx <= bidx + 3'd1;
              end
            end
          end else if (scl_fall) begin
            if (got_ack) begin
              state <= ST_TX;  bitc <= '0;
              tx_sh <= cur_byte;  sda_oe <= ~cur_byte[7];
            end else begin
              state <= ST_IDLE;  sda_oe <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9: the SDA pull-down moves only after a detected SCL fall, start or stop
  a_r9_oe_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || cond_start || cond_stop));

  // R2: a stop always leaves SDA released
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    cond_stop |=> !sda_oe);

  // R1: an idle slave never holds the bus
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R6: a word is stored only while the final byte's acknowledge is being held
  a_r6_commit_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe);

  // R7: nothing is stored once the pointer has left the map
  a_r7_no_commit_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sub <= LAST_SUB));

endmodule

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       sda_oe;
  wire        sda_bus = m_sda & ~sda_oe;

  i2c_regport u_dut (
    .clk, .rst_n, .scl_i(scl), .sda_i(sda_bus), .addr_strap(strap), .sda_oe
  );

  int errs = 0, checks = 0;
  bit quiet = 1'b0;
  longint unsigned mdl [N];
  bit acks [$];

  function automatic int wid(int i); return (i % 5) + 1; endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  // R9: the slave must not pull SDA while the host owns a bit or the bus is idle
  always @(negedge clk)
    if (rst_n && quiet) chk(!sda_oe, "R9", sda_oe, 0);

  task automatic start_c();
    quiet = 1'b0;
    wt(10); m_sda = 1'b1; wt(10); scl = 1'b1; wt(10); m_sda = 1'b0; wt(10); scl = 1'b0;
  endtask

  task automatic stop_c();
    wt(10); m_sda = 1'b0; wt(10); scl = 1'b1; wt(10); m_sda = 1'b1; wt(10);
    quiet = 1'b1;
  endtask

  task automatic bit_out(bit b);
    wt(10); m_sda = b; wt(10); scl = 1'b1; quiet = 1'b1; wt(20); quiet = 1'b0; scl = 1'b0;
  endtask

  task automatic bit_in(output bit b);
    wt(10); m_sda = 1'b1; wt(10); scl = 1'b1; wt(10); b = sda_bus; wt(10); scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    acks.push_back(!b);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
    bit_out(!ack);
  endtask

  function automatic logic [7:0] abyte(bit rw);
    return {5'b01101, strap, rw};
  endfunction

  task automatic do_write(int sa, logic [7:0] d [$], string tag);
    bit e [$];
    int idx = sa, k = 0;
    longint unsigned acc = 0;
    bit live = (sa < N);
    acks.delete();
    start_c();
    send_byte(abyte(1'b0));
    send_byte(8'(sa >> 8));
    send_byte(8'(sa));
    foreach (d[j]) send_byte(d[j]);
    stop_c();
    e.push_back(1'b1); e.push_back(1'b1); e.push_back(live);
    foreach (d[j]) begin
      if (live && idx < N) begin
        e.push_back(1'b1);
        acc = (acc << 8) | longint'(d[j]);
        k++;
        if (k == wid(idx)) begin mdl[idx] = acc; idx++; k = 0; acc = 0; end
      end else begin
        live = 1'b0;
        e.push_back(1'b0);
      end
    end
    for (int i = 0; i < e.size(); i++) chk(acks[i] == e[i], tag, acks[i], e[i]);
  endtask

  task automatic do_read(int sa, int n, string tag);
    logic [7:0] v, ev;
    int idx = (sa > N - 1) ? N - 1 : sa;
    int k = 0;
    acks.delete();
    start_c();
    send_byte(abyte(1'b0));
    send_byte(8'(sa >> 8));
    send_byte(8'(sa));
    start_c();
    send_byte(abyte(1'b1));
    for (int i = 0; i < 4; i++) chk(acks[i] == 1'b1, tag, acks[i], 1);
    for (int j = 0; j < n; j++) begin
      recv_byte(v, j != n - 1);
      ev = 8'(mdl[idx] >> (8 * (wid(idx) - 1 - k)));
      chk(v == ev, tag, v, ev);
      k++;
      if (k == wid(idx)) begin k = 0; if (idx < N - 1) idx++; end
    end
    wt(5);
    chk(!sda_oe, "R8", sda_oe, 0);   // R8: NACK ended the read
    stop_c();
  endtask

  initial begin
    foreach (mdl[i]) mdl[i] = 0;
    wt(3);
    chk(!sda_oe, "R10", sda_oe, 0);
    rst_n = 1'b1;
    wt(10);
    chk(!sda_oe, "R10", sda_oe, 0);
    quiet = 1'b1;

    // R10: all entries read back as zero after reset
    do_read(0, 6, "R10");

    // R1: foreign address is not acknowledged and the rest is ignored
    acks.delete();
    start_c(); send_byte(8'h6C); send_byte(8'h00); stop_c();
    chk(acks[0] == 1'b0, "R1", acks[0], 0);
    chk(acks[1] == 1'b0, "R1", acks[1], 0);

    // R4: five-byte entry, MSB byte first
    do_write(4, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, "R4");
    do_read(4, 5, "R4");

    // R5: burst through entries of widths 1, 2, 3
    do_write(0, '{8'hA1, 8'hB1, 8'hB2, 8'hC1, 8'hC2, 8'hC3}, "R5");
    do_read(0, 6, "R5");

    // R6: second word cut short by a stop is discarded
    do_write(5, '{8'h5A, 8'h61}, "R6");
    do_read(5, 3, "R6");

    // R7: write beyond the last entry
    do_write(7, '{8'h71, 8'h72, 8'h73, 8'hEE, 8'hEF}, "R7");
    do_read(4, 5, "R7");

    // R8: read past the end repeats the last entry
    do_read(6, 11, "R8");

    // R3: out-of-range subaddresses
    do_write(16'h0100, '{8'h99}, "R3");
    do_write(8, '{8'h98}, "R3");
    do_read(0, 6, "R3");

    // R2: start in the middle of a byte, then a clean transfer
    start_c(); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    do_write(1, '{8'hD1, 8'hD2}, "R2");
    do_read(1, 2, "R2");

    // R2: stop in the middle of a data byte leaves the entry unchanged
    acks.delete();
    start_c(); send_byte(abyte(1'b0)); send_byte(8'h00); send_byte(8'h02);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    stop_c();
    for (int i = 0; i < 3; i++) chk(acks[i] == 1'b1, "R2", acks[i], 1);
    do_read(2, 3, "R2");

    // R1: new strap value moves the address
    strap = 2'b10;
    do_write(3, '{8'h31, 8'h32, 8'h33, 8'h34}, "R1");
    do_read(3, 4, "R1");
    acks.delete();
    start_c(); send_byte(8'h6A); stop_c();
    chk(acks[0] == 1'b0, "R1", acks[0], 0);

    wt(20);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule